// File: doc/BRIEF.md
# Device-Under-Test Dump Supervisor

This block watches over a processor that is being exposed to radiation. At a fixed period, set by a clock-divider parameter (one second at the intended clock), it sends a one-cycle interrupt to the device under test. The device's handler must then return a register dump of exactly `DUMP_WORDS` words (80 by default). The words arrive one at a time on a 32-bit parallel bus, each marked by a one-cycle strobe. The block stores the whole dump in local storage. Once the last word is in, it raises an interrupt towards a host-side processor. The host then drains the words and the event counters through an addressed read port.

Two saturating counters keep track of faults. The first counts reset events, which are rising edges on the device's reset indicator after synchronization. The second counts timeouts. A timeout is either a dump that did not complete within `timeout_limit` cycles or a period that had to be skipped because the previous dump was still unread.

The controller is a four-state machine:
- `ST_IDLE` waits for the period tick and then goes to `ST_IRQ`.
- `ST_IRQ` drives the device interrupt for one cycle and always goes to `ST_CAPTURE`.
- `ST_CAPTURE` stores strobed words. It goes to `ST_HOLD` on the last word. It returns to `ST_IDLE` on expiry of the window, which is the timeout transition.
- `ST_HOLD` keeps the dump for the host. It counts every tick it sees as a missed period. A read of the last word address leaves it, going to `ST_IDLE`, or to `ST_IRQ` if a tick arrives in the same cycle.

Top module: `dut_supervisor`

## Requirements
- R1: `dev_irq` is high for exactly one cycle. While the block is idle, successive device interrupts are exactly `PERIOD_CYCLES` cycles apart.
- R2: During capture, each cycle with `dev_strobe` high stores `dev_data` at the next buffer address, starting at address 0 after each device interrupt.
- R3: The host interrupt is asserted in the cycle after the strobe that delivers the last dump word. It stays high until `host_ack` is seen, and it is low in the cycle after the acknowledge.
- R4: A read is registered. `host_rd_data` is valid in the cycle after `host_rd_en`. Addresses 0 to DUMP_WORDS-1 return buffered words. Address DUMP_WORDS returns the reset-event count and DUMP_WORDS+1 returns the timeout count, both zero-extended. Any other address returns 0.
- R5: If the dump is not complete within `timeout_limit` cycles after the device-interrupt cycle, the timeout count increments by one. The partial dump is dropped and no host interrupt is raised. The next period interrupts the device again, and that capture starts again at address 0.
- R6: If a period tick arrives while a complete dump is still unread, no device interrupt is issued and the timeout count increments by one.
- R7: A host read of address DUMP_WORDS-1 releases the buffer, and the next period tick issues a device interrupt again. Reads of other addresses do not release it.
- R8: Each rising edge of `dev_reset_ind` increments the reset count once, after a two-flop synchronizer. A level held high counts only once.
- R9: Both counters stop at 2^CNT_W-1 and do not wrap.
- R10: Strobes outside capture, whether idle or while a dump is held, do not change the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| timeout_limit | input | TIMEOUT_W | Capture window length in cycles (at least 1) |
| dev_irq | output | 1 | One-cycle interrupt to the device under test |
| dev_data | input | DATA_W | Dump word from the device |
| dev_strobe | input | 1 | One-cycle word-valid strobe |
| dev_reset_ind | input | 1 | Asynchronous device reset indicator |
| host_irq | output | 1 | Dump-ready interrupt to the host |
| host_ack | input | 1 | Host acknowledge of the interrupt |
| host_rd_en | input | 1 | Host read request |
| host_rd_addr | input | AW | Host read address |
| host_rd_data | output | DATA_W | Read data, one cycle after the request |

## Verification
These are the latencies the bench relies on:
- A device interrupt appears one cycle after the period tick. The first capture cycle follows it, so the bench starts strobing one cycle after it sees `dev_irq`.
- The host interrupt rises one cycle after the last strobe and falls one cycle after the acknowledge.
- Read data follows the request by one cycle.
- A reset-indicator edge reaches the counter three cycles later.

All inputs are driven on the falling edge and all outputs are sampled on a falling edge. For edge-exact results the bench samples at the specified falling edge. It checks the value both just before and just after the change. Counter results carry no timing promise, so the bench waits several cycles after the stimulus before reading them. Period spacing is measured on a free-running cycle count between two observed interrupts.

// File: rtl/sup_pkg.sv
package sup_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_IRQ     = 2'd1,
        ST_CAPTURE = 2'd2,
        ST_HOLD    = 2'd3
    } sup_state_e;
endpackage

// File: rtl/sup_period_timer.sv
module sup_period_timer #(
    parameter int PERIOD_CYCLES = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = $clog2(PERIOD_CYCLES);

    logic [CW-1:0] cnt;

    assign tick = (cnt == CW'(PERIOD_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    // R1: a period tick never lasts two cycles
    a_r1_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/sup_rise_detect.sv
module sup_rise_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic s1, s2, s3;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= async_in;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign rise = s2 & ~s3;

    // R8: one edge yields one event
    a_r8_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/sup_sat_counter.sv
module sup_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n)                    count <= '0;
        else if (inc && count != MAXV) count <= count + 1'b1;
    end

    // R9: a full counter stays full
    a_r9_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (count == MAXV) |=> (count == MAXV));
    // R8: no event, no change
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(count));
    // R9: below the ceiling an event adds exactly one
    a_r9_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && count != MAXV) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/sup_dump_buffer.sv
module sup_dump_buffer #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 80,
    parameter int CNT_W  = 16,
    parameter int PW     = $clog2(DEPTH),
    parameter int AW     = $clog2(DEPTH + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    input  logic [CNT_W-1:0]  rst_cnt,
    input  logic [CNT_W-1:0]  to_cnt,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rd_mux;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    always_comb begin
        if (rd_addr < AW'(DEPTH))        rd_mux = mem[rd_addr[PW-1:0]];
        else if (rd_addr == AW'(DEPTH))  rd_mux = DATA_W'(rst_cnt);
        else if (rd_addr == AW'(DEPTH+1)) rd_mux = DATA_W'(to_cnt);
        else                             rd_mux = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
    end

    // R2: writes stay inside the storage
    a_r2_wr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr < PW'(DEPTH)));
    // R4: read data only moves on a request
    a_r4_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/dut_supervisor.sv
module dut_supervisor #(
    parameter int PERIOD_CYCLES = 50_000_000,
    parameter int DUMP_WORDS    = 80,
    parameter int DATA_W        = 32,
    parameter int CNT_W         = 16,
    parameter int TIMEOUT_W     = 24,
    parameter int AW            = $clog2(DUMP_WORDS + 2)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [TIMEOUT_W-1:0] timeout_limit,
    output logic                 dev_irq,
    input  logic [DATA_W-1:0]    dev_data,
    input  logic                 dev_strobe,
    input  logic                 dev_reset_ind,
    output logic                 host_irq,
    input  logic                 host_ack,
    input  logic                 host_rd_en,
    input  logic [AW-1:0]        host_rd_addr,
    output logic [DATA_W-1:0]    host_rd_data
);
    import sup_pkg::*;

    localparam int PW = $clog2(DUMP_WORDS);
    localparam logic [PW-1:0] LAST_PTR  = PW'(DUMP_WORDS - 1);
    localparam logic [AW-1:0] LAST_ADDR = AW'(DUMP_WORDS - 1);

    sup_state_e           state, state_nx;
    logic                 tick;
    logic [PW-1:0]        wr_ptr;
    logic [TIMEOUT_W-1:0] wait_cnt;
    logic                 cap_we, done_ev, expire_ev, missed_ev;
    logic [1:0]           ev_inc;
    logic [CNT_W-1:0]     ev_cnt [2];

    sup_period_timer #(.PERIOD_CYCLES(PERIOD_CYCLES)) i_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick));

    sup_rise_detect i_rst_edge (
        .clk(clk), .rst_n(rst_n), .async_in(dev_reset_ind), .rise(ev_inc[0]));

    assign ev_inc[1] = expire_ev | missed_ev;

    for (genvar g = 0; g < 2; g++) begin : g_evcnt
        sup_sat_counter #(.W(CNT_W)) i_cnt (
            .clk(clk), .rst_n(rst_n), .inc(ev_inc[g]), .count(ev_cnt[g]));
    end

    sup_dump_buffer #(.DATA_W(DATA_W), .DEPTH(DUMP_WORDS), .CNT_W(CNT_W),
                      .PW(PW), .AW(AW)) i_buf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cap_we), .wr_addr(wr_ptr), .wr_data(dev_data),
        .rd_en(host_rd_en), .rd_addr(host_rd_addr),
        .rst_cnt(ev_cnt[0]), .to_cnt(ev_cnt[1]),
        .rd_data(host_rd_data));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state and transition events
    always_comb begin
        state_nx  = state;
        done_ev   = 1'b0;
        expire_ev = 1'b0;
        missed_ev = 1'b0;
        unique case (state)
            ST_IDLE: if (tick) state_nx = ST_IRQ;
            ST_IRQ:  state_nx = ST_CAPTURE;
            ST_CAPTURE: begin
                if (dev_strobe && wr_ptr == LAST_PTR) begin
                    state_nx = ST_HOLD;
                    done_ev  = 1'b1;
                end else if (wait_cnt == timeout_limit - TIMEOUT_W'(1)) begin
                    state_nx  = ST_IDLE;
                    expire_ev = 1'b1;
                end
            end
            ST_HOLD: begin
                if (host_rd_en && host_rd_addr == LAST_ADDR)
                    state_nx = tick ? ST_IRQ : ST_IDLE;
                else if (tick)
                    missed_ev = 1'b1;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        dev_irq = (state == ST_IRQ);
        cap_we  = (state == ST_CAPTURE) && dev_strobe;
    end

    // capture pointer and window counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            wait_cnt <= '0;
        end else if (state == ST_IRQ) begin
            wr_ptr   <= '0;
            wait_cnt <= '0;
        end else if (state == ST_CAPTURE) begin
            wait_cnt <= wait_cnt + 1'b1;
            if (cap_we) wr_ptr <= wr_ptr + 1'b1;
        end
    end

    // host interrupt flag: set on completion, cleared by acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)        host_irq <= 1'b0;
        else if (done_ev)  host_irq <= 1'b1;
        else if (host_ack) host_irq <= 1'b0;
    end

    // R1: the device interrupt is a single-cycle pulse
    a_r1_dev_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        dev_irq |=> !dev_irq);
    // R3: host interrupt persists until acknowledged
    a_r3_host_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (host_irq && !host_ack) |=> host_irq);
    // R3: host interrupt only drops after an acknowledge
    a_r3_host_irq_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(host_irq) |-> $past(host_ack));
    // R2: capture never runs past the last buffer slot
    a_r2_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CAPTURE) |-> (wr_ptr <= LAST_PTR));
    // R6: a held dump is never followed directly by capture
    a_r6_hold_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |=> (state != ST_CAPTURE));
endmodule

// File: tb/test_dut_supervisor.sv
module test_dut_supervisor;
    localparam int PERIOD = 2000;
    localparam int WORDS  = 80;
    localparam int CW     = 4;
    localparam int TW     = 16;
    localparam int AWB    = 7;
    localparam int TLIM   = 300;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [TW-1:0]   timeout_limit = TW'(TLIM);
    logic            dev_irq;
    logic [31:0]     dev_data = '0;
    logic            dev_strobe = 1'b0;
    logic            dev_reset_ind = 1'b0;
    logic            host_irq;
    logic            host_ack = 1'b0;
    logic            host_rd_en = 1'b0;
    logic [AWB-1:0]  host_rd_addr = '0;
    logic [31:0]     host_rd_data;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int exp_to = 0;
    int exp_rst = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dut_supervisor #(.PERIOD_CYCLES(PERIOD), .DUMP_WORDS(WORDS), .DATA_W(32),
                     .CNT_W(CW), .TIMEOUT_W(TW)) i_dut_supervisor (
        .clk(clk), .rst_n(rst_n), .timeout_limit(timeout_limit),
        .dev_irq(dev_irq), .dev_data(dev_data), .dev_strobe(dev_strobe),
        .dev_reset_ind(dev_reset_ind), .host_irq(host_irq), .host_ack(host_ack),
        .host_rd_en(host_rd_en), .host_rd_addr(host_rd_addr),
        .host_rd_data(host_rd_data));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input int addr, output logic [31:0] data);
        @(negedge clk);
        host_rd_en   = 1'b1;
        host_rd_addr = AWB'(addr);
        @(negedge clk);
        host_rd_en = 1'b0;
        data = host_rd_data;
    endtask

    // returns at the falling edge where dev_irq is high
    task automatic wait_irq(input int limit, output bit seen, output int at);
        seen = 1'b0;
        at = 0;
        for (int i = 0; i < limit && !seen; i++) begin
            @(negedge clk);
            if (dev_irq) begin
                seen = 1'b1;
                at = cyc;
            end
        end
    endtask

    // strobes words starting in the first capture cycle; checks R3 edge timing
    task automatic send_dump(input int n, input logic [31:0] base, input bit full);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (full && i == n - 1) check("R3 host_irq low before last word", 32'(host_irq), 0);
            dev_strobe = 1'b1;
            dev_data   = base + 32'(i) * 32'h0101_0007;
        end
        @(negedge clk);
        dev_strobe = 1'b0;
        dev_data   = 32'hDEAD_BEEF;
        if (full) check("R3 host_irq high after last word", 32'(host_irq), 1);
    endtask

    task automatic junk_strobes(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            dev_strobe = 1'b1;
            dev_data   = 32'hBAD0_0000 + 32'(i);
        end
        @(negedge clk);
        dev_strobe = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        check("R1 dev_irq low after reset", 32'(dev_irq), 0);
        check("R3 host_irq low after reset", 32'(host_irq), 0);
        rd(WORDS, d);     check("R4 reset count starts 0", d, 0);
        rd(WORDS + 1, d); check("R4 timeout count starts 0", d, 0);
        rd(WORDS + 5, d); check("R4 unmapped address reads 0", d, 0);
    endtask

    task automatic t_timeout_and_period();
        bit seen; int a1, a2;
        logic [31:0] d;
        junk_strobes(5);  // R10: idle strobes
        wait_irq(PERIOD + 10, seen, a1);
        check("R1 first device interrupt seen", 32'(seen), 1);
        @(negedge clk);
        check("R1 dev_irq one cycle wide", 32'(dev_irq), 0);
        exp_to++;  // no reply at all
        wait_irq(PERIOD + 10, seen, a2);
        check("R1 second device interrupt seen", 32'(seen), 1);
        check("R1 interrupt spacing", 32'(a2 - a1), 32'(PERIOD));
        send_dump(10, 32'h7000_0000, 1'b0);  // R5: partial dump
        exp_to++;
        repeat (TLIM + 20) @(negedge clk);
        check("R5 no host_irq after partial dump", 32'(host_irq), 0);
        rd(WORDS + 1, d);
        check("R5 timeout count after two expiries", d, 32'(exp_to));
    endtask

    task automatic t_full_dump();
        bit seen; int a;
        bit irq_seen;
        logic [31:0] d;
        wait_irq(PERIOD + 10, seen, a);
        check("R5 interrupt issued after timeout", 32'(seen), 1);
        send_dump(WORDS, 32'hA500_0000, 1'b1);
        junk_strobes(3);  // R10: strobes while held
        repeat (4) @(negedge clk);
        check("R3 host_irq held until ack", 32'(host_irq), 1);
        host_ack = 1'b1;
        @(negedge clk);
        host_ack = 1'b0;
        check("R3 host_irq low after ack", 32'(host_irq), 0);
        // R6: unread dump blocks the next period
        irq_seen = 1'b0;
        for (int i = 0; i < PERIOD + 10; i++) begin
            @(negedge clk);
            if (dev_irq) irq_seen = 1'b1;
        end
        check("R6 no device interrupt while dump unread", 32'(irq_seen), 0);
        exp_to++;
        rd(WORDS + 1, d);
        check("R6 missed period counted", d, 32'(exp_to));
        // R7: a non-last read does not release
        rd(3, d);
        check("R2 word 3 content", d, 32'hA500_0000 + 32'd3 * 32'h0101_0007);
        // R2/R10/R5: read back the whole dump, last read releases
        for (int i = 0; i < WORDS; i++) begin
            rd(i, d);
            check("R2 buffered word", d, 32'hA500_0000 + 32'(i) * 32'h0101_0007);
        end
        wait_irq(PERIOD + 10, seen, a);
        check("R7 interrupt resumes after last-word read", 32'(seen), 1);
        send_dump(WORDS, 32'h1234_0000, 1'b1);
        rd(0, d);         check("R2 second dump word 0", d, 32'h1234_0000);
        rd(WORDS - 2, d); check("R2 second dump word 78", d, 32'h1234_0000 + 32'(WORDS - 2) * 32'h0101_0007);
        @(negedge clk);
        host_ack = 1'b1;
        @(negedge clk);
        host_ack = 1'b0;
        check("R3 second ack clears host_irq", 32'(host_irq), 0);
    endtask

    task automatic t_reset_events();
        logic [31:0] d;
        @(negedge clk); dev_reset_ind = 1'b1;
        repeat (3) @(negedge clk); dev_reset_ind = 1'b0;
        repeat (6) @(negedge clk);
        exp_rst = 1;
        rd(WORDS, d);
        check("R8 single pulse counted once", d, 32'(exp_rst));
        dev_reset_ind = 1'b1;
        repeat (20) @(negedge clk);
        dev_reset_ind = 1'b0;
        repeat (6) @(negedge clk);
        exp_rst = 2;
        rd(WORDS, d);
        check("R8 held level counted once", d, 32'(exp_rst));
        for (int i = 0; i < 20; i++) begin
            dev_reset_ind = 1'b1;
            repeat (3) @(negedge clk);
            dev_reset_ind = 1'b0;
            repeat (3) @(negedge clk);
        end
        repeat (6) @(negedge clk);
        rd(WORDS, d);
        check("R9 reset count saturates", d, 32'((1 << CW) - 1));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_timeout_and_period();
        t_full_dump();
        t_reset_events();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 150_000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule